// File: doc/BRIEF.md
# Debug address breakpoint comparator

This block is the trigger front end of an on-chip debug unit. A debugger loads a small set of write-only registers through a register write port that carries a register code and a data word. The block then watches the address of every transfer on the processor's local bus. It raises a one-cycle match strobe whenever that address meets the selected condition. The condition is one of three: equal to the low bound, inside the inclusive low-to-high window, or outside that window.

A second comparator watches instruction-fetch addresses. It matches them against a program-counter breakpoint value. A mask register sets, bit by bit, which positions must agree and which are ignored. Both strobes are registered and qualified by their valid inputs. A later trigger sequencer can sample them directly. The address space is 24 bits wide. The upper byte of any 32-bit value is dropped before storage or comparison.

Top module: `dbg_addr_trig`

## Requirements
- R1: While reset is asserted and right after it is released, `addr_match` and `pc_match` are 0 and the low bound register holds zero. The trigger-definition register resets to 0, so both triggers start disabled. The high bound and the PC mask reset to all ones.
- R2: A write with `reg_wr_en`=1 loads `reg_wdata` into one register, selected by `reg_code`:
  - 0x0D: low bound
  - 0x0C: high bound
  - 0x09: PC mask
  - 0x08: PC breakpoint value
  - 0x07: trigger definition
  
  The new value takes effect for transfers presented in the cycle after the write.
- R3: When trigger-definition bits [1:0] are 00, the address trigger is disabled and `addr_match` stays 0.
- R4: With bits [1:0] = 01 (equal), a valid transfer whose address equals the low bound gives `addr_match`=1.
- R5: With bits [1:0] = 10 (inside), a valid transfer whose address satisfies low <= addr <= high gives `addr_match`=1. Both bounds count as inside.
- R6: With bits [1:0] = 11 (outside), a valid transfer whose address is below low or above high gives `addr_match`=1. The bounds themselves do not match.
- R7: Only bits 23:0 take part. The upper byte of `bus_addr`, `fetch_pc` and `reg_wdata` has no effect on any match.
- R8: `addr_match` is asserted exactly one clock after a cycle with `bus_valid`=1 that meets the condition. It is 0 one clock after any cycle with `bus_valid`=0.
- R9: The PC match works as follows:
  - `pc_match` is 1 one clock after a cycle in which `fetch_valid`=1 and trigger-definition bit 2 is 1.
  - That fetch cycle must also meet ((pc ^ value) & ~mask) == 0 on bits 23:0.
  - A mask bit of 1 makes that bit a don't-care.
- R10: A write with any other register code changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Debug register write strobe |
| reg_code | input | 8 | Debug register code |
| reg_wdata | input | 32 | Write data |
| bus_valid | input | 1 | Local-bus transfer valid |
| bus_addr | input | 32 | Local-bus transfer address |
| fetch_valid | input | 1 | Instruction-fetch valid |
| fetch_pc | input | 32 | Instruction-fetch address |
| addr_match | output | 1 | Registered address trigger strobe |
| pc_match | output | 1 | Registered PC trigger strobe |

## Verification
The assertions assume the following about the inputs:
- Register writes and bus transfers are sampled only on rising clock edges.
- The debugger never writes during reset.
- A write and a transfer presented in the same cycle compare against the old register values.

The stimulus drives every input half a cycle away from the active edge. Writes happen only after reset has been released. Random addresses are biased toward the bounds and one step beyond them, with a random upper byte. This keeps the inclusive edges and the truncation rule under steady exercise.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

  typedef enum logic [1:0] {
    AM_OFF = 2'b00,
    AM_EQ  = 2'b01,
    AM_IN  = 2'b10,
    AM_OUT = 2'b11
  } amode_e;

  localparam logic [7:0] CODE_TDEF  = 8'h07;
  localparam logic [7:0] CODE_PBR   = 8'h08;
  localparam logic [7:0] CODE_PMASK = 8'h09;
  localparam logic [7:0] CODE_AHI   = 8'h0C;
  localparam logic [7:0] CODE_ALO   = 8'h0D;

  localparam int TDEF_PCEN_BIT = 2;

endpackage

// File: rtl/dbg_trig_regs.sv
module dbg_trig_regs
  import dbg_trig_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_code,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] lo,
  output logic [ADDR_W-1:0] hi,
  output logic [ADDR_W-1:0] pbr,
  output logic [ADDR_W-1:0] pmask,
  output amode_e            amode,
  output logic              pc_en
);

  logic ld_lo, ld_hi, ld_pbr, ld_pmask, ld_tdef;
  logic [ADDR_W-1:0] lo_q, hi_q, pbr_q, pmask_q;
  amode_e amode_q, amode_d;
  logic   pcen_q, pcen_d;

  // load enables
  always_comb begin
    ld_lo    = 1'b0;
    ld_hi    = 1'b0;
    ld_pbr   = 1'b0;
    ld_pmask = 1'b0;
    ld_tdef  = 1'b0;
    if (wr_en) begin
      case (wr_code)
        CODE_ALO:   ld_lo    = 1'b1;
        CODE_AHI:   ld_hi    = 1'b1;
        CODE_PBR:   ld_pbr   = 1'b1;
        CODE_PMASK: ld_pmask = 1'b1;
        CODE_TDEF:  ld_tdef  = 1'b1;
        default:    ;
      endcase
    end
    amode_d = amode_e'(wr_data[1:0]);
    pcen_d  = wr_data[TDEF_PCEN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      hi_q    <= '1;
      pbr_q   <= '0;
      pmask_q <= '1;
      amode_q <= AM_OFF;
      pcen_q  <= 1'b0;
    end else begin
      if (ld_lo)    lo_q    <= wr_data;
      if (ld_hi)    hi_q    <= wr_data;
      if (ld_pbr)   pbr_q   <= wr_data;
      if (ld_pmask) pmask_q <= wr_data;
      if (ld_tdef) begin
        amode_q <= amode_d;
        pcen_q  <= pcen_d;
      end
    end
  end

  assign lo    = lo_q;
  assign hi    = hi_q;
  assign pbr   = pbr_q;
  assign pmask = pmask_q;
  assign amode = amode_q;
  assign pc_en = pcen_q;

endmodule

// File: rtl/dbg_addr_cmp.sv
module dbg_addr_cmp
  import dbg_trig_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  amode_e            mode,
  output logic              match
);

  logic eq_lo, ge_lo, le_hi, in_win, hit, match_d, match_q;

  always_comb begin
    eq_lo  = (addr == lo);
    ge_lo  = (addr >= lo);
    le_hi  = (addr <= hi);
    in_win = ge_lo && le_hi;
    case (mode)
      AM_EQ:   hit = eq_lo;
      AM_IN:   hit = in_win;
      AM_OUT:  hit = !in_win;
      default: hit = 1'b0;
    endcase
    match_d = valid && hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match_d;
  end

  assign match = match_q;

endmodule

// File: rtl/dbg_pc_cmp.sv
module dbg_pc_cmp #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              en,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] pbr,
  input  logic [ADDR_W-1:0] pmask,
  output logic              match
);

  logic [ADDR_W-1:0] bit_ok;
  logic match_d, match_q;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    assign bit_ok[i] = pmask[i] | ~(pc[i] ^ pbr[i]);
  end

  always_comb match_d = valid && en && (&bit_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match_d;
  end

  assign match = match_q;

endmodule

// File: rtl/dbg_addr_trig.sv
module dbg_addr_trig
  import dbg_trig_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [7:0]        reg_code,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              bus_valid,
  input  logic [DATA_W-1:0] bus_addr,
  input  logic              fetch_valid,
  input  logic [DATA_W-1:0] fetch_pc,
  output logic              addr_match,
  output logic              pc_match
);

  localparam int HI_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] lo, hi, pbr, pmask;
  amode_e amode;
  logic   pc_en;

  // upper byte is outside the address map
  logic unused_hi;
  assign unused_hi = ^{reg_wdata[DATA_W-1 -: HI_W], bus_addr[DATA_W-1 -: HI_W],
                       fetch_pc[DATA_W-1 -: HI_W]};

  dbg_trig_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wr_code (reg_code),
    .wr_data (reg_wdata[ADDR_W-1:0]),
    .lo      (lo),
    .hi      (hi),
    .pbr     (pbr),
    .pmask   (pmask),
    .amode   (amode),
    .pc_en   (pc_en)
  );

  dbg_addr_cmp #(.ADDR_W(ADDR_W)) u_acmp (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (bus_valid),
    .addr  (bus_addr[ADDR_W-1:0]),
    .lo    (lo),
    .hi    (hi),
    .mode  (amode),
    .match (addr_match)
  );

  dbg_pc_cmp #(.ADDR_W(ADDR_W)) u_pcmp (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (fetch_valid),
    .en    (pc_en),
    .pc    (fetch_pc[ADDR_W-1:0]),
    .pbr   (pbr),
    .pmask (pmask),
    .match (pc_match)
  );

endmodule

// File: rtl/dbg_trig_chk.sv
module dbg_trig_chk
  import dbg_trig_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [7:0]        reg_code,
  input logic              bus_valid,
  input logic              fetch_valid,
  input logic              addr_match,
  input logic              pc_match,
  input amode_e            amode,
  input logic              pc_en,
  input logic [ADDR_W-1:0] lo
);

  logic seen_rst;
  always_ff @(posedge clk) seen_rst <= !rst_n;

  // R1: reset holds outputs low and clears the low bound
  always @(posedge clk) begin
    if (seen_rst && !rst_n) begin
      p_reset_state_r1: assert (lo == '0 && !addr_match && !pc_match);
    end
  end

  // R8: a strobe needs a valid transfer one cycle earlier
  p_addr_qual_r8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_match |-> $past(bus_valid));

  // R3: disabled mode never produces a strobe
  p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_match |-> ($past(amode) != AM_OFF));

  // R9: PC strobe needs a fetch while enabled
  p_pc_qual_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_match |-> $past(fetch_valid && pc_en));

  // R10: low bound only changes through its own code
  p_lo_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_code == CODE_ALO) |=> $stable(lo));

endmodule

bind dbg_addr_trig dbg_trig_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_en   (reg_wr_en),
  .reg_code    (reg_code),
  .bus_valid   (bus_valid),
  .fetch_valid (fetch_valid),
  .addr_match  (addr_match),
  .pc_match    (pc_match),
  .amode       (amode),
  .pc_en       (pc_en),
  .lo          (lo)
);

// File: tb/sim_dbg_addr_trig.sv
`timescale 1ns/1ps
module sim_dbg_addr_trig;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [7:0]  reg_code;
  logic [31:0] reg_wdata;
  logic        bus_valid;
  logic [31:0] bus_addr;
  logic        fetch_valid;
  logic [31:0] fetch_pc;
  logic        addr_match;
  logic        pc_match;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // bench model of the register state
  logic [23:0] m_lo, m_hi, m_pbr, m_mask;
  logic [1:0]  m_mode;
  bit          m_pcen;

  always #2.5 clk = ~clk;

  dbg_addr_trig u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_code(reg_code),
    .reg_wdata(reg_wdata), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .addr_match(addr_match), .pc_match(pc_match)
  );

  function automatic bit exp_addr(bit bv, logic [31:0] a);
    logic [23:0] x;
    bit in_w;
    x = a[23:0];
    in_w = (x >= m_lo) && (x <= m_hi);
    if (!bv) return 1'b0;
    case (m_mode)
      2'b01:   return x == m_lo;
      2'b10:   return in_w;
      2'b11:   return !in_w;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit exp_pc(bit fv, logic [31:0] pc);
    return fv && m_pcen && (((pc[23:0] ^ m_pbr) & ~m_mask) == 24'h0);
  endfunction

  function automatic string addr_tag(bit bv);
    if (!bv) return "R8";
    case (m_mode)
      2'b01:   return "R4";
      2'b10:   return "R5";
      2'b11:   return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic model_write(bit we, logic [7:0] code, logic [31:0] d);
    if (!we) return;
    case (code)
      8'h0D: m_lo   = d[23:0];
      8'h0C: m_hi   = d[23:0];
      8'h09: m_mask = d[23:0];
      8'h08: m_pbr  = d[23:0];
      8'h07: begin m_mode = d[1:0]; m_pcen = d[2]; end
      default: ;
    endcase
  endtask

  task automatic check(string req, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // called just after a falling edge
  task automatic step(bit we, logic [7:0] code, logic [31:0] d,
                      bit bv, logic [31:0] a, bit fv, logic [31:0] pc,
                      string tag);
    bit ea, ep;
    string ta;
    reg_wr_en = we; reg_code = code; reg_wdata = d;
    bus_valid = bv; bus_addr = a; fetch_valid = fv; fetch_pc = pc;
    @(posedge clk);
    ea = exp_addr(bv, a);
    ep = exp_pc(fv, pc);
    ta = (tag != "") ? tag : addr_tag(bv);
    model_write(we, code, d);
    @(negedge clk);
    check({ta, " addr_match"}, addr_match, ea);
    check({(tag != "") ? tag : "R9", " pc_match"}, pc_match, ep);
  endtask

  task automatic wr(logic [7:0] code, logic [31:0] d, string tag);
    step(1, code, d, 0, 32'h0, 0, 32'h0, tag);
  endtask

  task automatic bus(logic [31:0] a, string tag);
    step(0, 8'h00, 32'h0, 1, a, 0, 32'h0, tag);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0;
    reg_wr_en = 0; reg_code = 0; reg_wdata = 0;
    bus_valid = 0; bus_addr = 0; fetch_valid = 0; fetch_pc = 0;
    m_lo = '0; m_hi = '1; m_pbr = '0; m_mask = '1; m_mode = 2'b00; m_pcen = 0;
    repeat (3) @(negedge clk);
    check("R1 addr_match in reset", addr_match, 1'b0);
    check("R1 pc_match in reset", pc_match, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 addr_match after reset", addr_match, 1'b0);

    // disabled after reset: a valid transfer at address 0 gives nothing
    bus(32'h0000_0000, "R3");
    // equal mode without loading the low bound: reset value zero matches
    wr(8'h07, 32'h1, "R2");
    bus(32'h5A00_0000, "R1");
    // unknown code does not disturb the low bound
    wr(8'h0E, 32'h0000_1234, "R10");
    bus(32'h0000_1234, "R10");
    bus(32'h0000_0000, "R10");
    // load bounds with junk in the upper byte
    wr(8'h0D, 32'hFF00_1000, "R7");
    wr(8'h0C, 32'hAB00_2000, "R7");
    bus(32'h0000_1000, "R4");
    bus(32'h7700_1000, "R7");
    bus(32'h0000_1001, "R4");
    // inside window edges
    wr(8'h07, 32'h2, "R2");
    bus(32'h0000_0FFF, "R5");
    bus(32'h0000_1000, "R5");
    bus(32'h0000_2000, "R5");
    bus(32'h0000_2001, "R5");
    // outside window edges
    wr(8'h07, 32'h3, "R2");
    bus(32'h0000_0FFF, "R6");
    bus(32'h0000_1000, "R6");
    bus(32'h0000_2000, "R6");
    bus(32'hFF00_2001, "R6");
    // no valid strobe, no match
    step(0, 8'h00, 0, 0, 32'h0000_0FFF, 0, 0, "R8");
    // write and transfer together: compare uses the old low bound
    wr(8'h07, 32'h1, "R2");
    step(1, 8'h0D, 32'h0000_3000, 1, 32'h0000_3000, 0, 0, "R2");
    bus(32'h0000_3000, "R2");
    // PC breakpoint with low nibble masked
    wr(8'h08, 32'h0012_3450, "R9");
    wr(8'h09, 32'h0000_000F, "R9");
    step(0, 0, 0, 0, 0, 1, 32'h0012_345F, "R9");  // not yet enabled
    wr(8'h07, 32'h4, "R9");
    step(0, 0, 0, 0, 0, 1, 32'h0012_345F, "R9");
    step(0, 0, 0, 0, 0, 1, 32'hEE12_3453, "R7");
    step(0, 0, 0, 0, 0, 1, 32'h0012_3460, "R9");
    step(0, 0, 0, 0, 0, 0, 32'h0012_3450, "R9");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit we, bv, fv;
      logic [7:0] code;
      logic [31:0] d, a, pc;
      int sel;
      we = ($urandom_range(0, 7) == 0);
      case ($urandom_range(0, 6))
        0: code = 8'h07;
        1: code = 8'h08;
        2: code = 8'h09;
        3: code = 8'h0C;
        4: code = 8'h0D;
        5: code = 8'h0E;
        default: code = 8'h00;
      endcase
      d = $urandom();
      if (code == 8'h09) d = d & 32'hFF00_00FF;
      bv = ($urandom_range(0, 3) != 0);
      fv = ($urandom_range(0, 1) != 0);
      sel = $urandom_range(0, 5);
      a[31:24] = 8'($urandom());
      case (sel)
        0: a[23:0] = m_lo;
        1: a[23:0] = m_lo - 24'd1;
        2: a[23:0] = m_hi;
        3: a[23:0] = m_hi + 24'd1;
        default: a[23:0] = 24'($urandom());
      endcase
      pc = {8'($urandom()), m_pbr ^ (24'($urandom()) & 24'h0000FF)};
      step(we, code, d, bv, a, fv, pc, "");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule